// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single transmit line. A low start bit opens each frame. The data bits follow least-significant first, then an optional parity bit, then one or two high stop bits. The line rests high between frames.

The frame shape comes from a small control register inside the block. That register sets the character width (5 to 8 bits), the number of stop bits, whether a parity bit is sent, and how the parity bit is formed. The parity bit can be odd, even, always 1 or always 0. One more control bit forces the line low (break) for as long as it stays set.

Bit timing comes from an external enable that pulses sixteen times per bit period. Characters arrive through a valid/ready handshake. The format is captured when a character is accepted, so a control write made during a frame affects only later frames.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is high, `busy` is 0, `char_ready` is 1, and the control register holds 0x03. A frame sent with no prior control write is therefore 8 data bits, no parity and one stop bit.
- R2: Control bits [1:0] hold the character width minus five. Data bits go out least-significant first.
- R3: Control bit 2 selects the stop bits: 0 sends one high stop bit and 1 sends two.
- R4: Control bit 3 adds one parity bit after the data. Control bits [5:4] form that bit:
  - 0: the total count of ones in data plus parity is odd.
  - 1: that total count is even.
  - 2: the parity bit is always 1.
  - 3: the parity bit is always 0.
- R5: Every bit of a frame lasts exactly 16 pulses of `tick16`. Clock cycles without a pulse do not advance the frame.
- R6: Each frame starts with a low start bit. Then come the data bits, then parity if enabled, then stop bits. The line is high whenever no frame is in progress and break is off.
- R7: While control bit 6 is 1, `txd` is 0. This holds whether or not a frame is in progress. A frame in progress keeps its timing underneath, and the frame's own level returns when the bit is cleared.
- R8: A character is accepted on a clock edge where `char_valid` and `char_ready` are both 1. `char_ready` drops at that edge and stays low until the edge that ends the last stop bit. `busy` is always the complement of `char_ready`.
- R9: A control write made during a frame does not alter that frame, except for break (R7). The written format applies from the next accepted character.
- R10: Data input bits above the selected width have no effect on the line or on the parity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable pulse, 16 per bit period |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 7 | Control value: width-5 [1:0], stop [2], parity enable [3], parity mode [5:4], break [6] |
| char_data | input | 8 | Character to send, bit 0 first |
| char_valid | input | 1 | Character offered |
| char_ready | output | 1 | Block can accept a character |
| txd | output | 1 | Serial transmit line |
| busy | output | 1 | A frame is in progress |

## Verification
The assertions take for granted that no control write arrives in a reset cycle. They also take for granted that `tick16` and the control strobe change only between clock edges. The property that the line holds still between tick pulses is qualified on cycles without a control write, because a break write may change the line at any time.

The stimulus drives every input on the falling clock edge. It issues control writes only as single-cycle strobes outside reset. It changes the tick spacing only while the block is idle, so each frame sees a fixed tick pattern. Tick spacings of one and three cycles are both used.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

    localparam int CTRL_W = 7;
    localparam int BRK_BIT = 6;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 7'h03;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_START  = 3'd1,
        PH_DATA   = 3'd2,
        PH_PARITY = 3'd3,
        PH_STOP   = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_MARK  = 2'd2,
        PAR_SPACE = 2'd3
    } par_mode_e;

    typedef struct packed {
        par_mode_e  par_mode;
        logic       par_en;
        logic       two_stop;
        logic [1:0] len_m5;
    } fmt_t;

    function automatic fmt_t fmt_decode(input logic [CTRL_W-1:0] v);
        fmt_t f;
        f.len_m5   = v[1:0];
        f.two_stop = v[2];
        f.par_en   = v[3];
        f.par_mode = par_mode_e'(v[5:4]);
        return f;
    endfunction

    function automatic logic [3:0] data_count(input logic [1:0] len_m5);
        return 4'(len_m5) + 4'd5;
    endfunction

    function automatic logic parity_out(input par_mode_e m, input logic ones_xor);
        logic p;
        unique case (m)
            PAR_ODD:   p = ~ones_xor;
            PAR_EVEN:  p = ones_xor;
            PAR_MARK:  p = 1'b1;
            default:   p = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/uftx_ctrl_reg.sv
module uftx_ctrl_reg
    import uftx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= CTRL_RESET;
        else if (we)
            q <= wdata;
    end
endmodule

// File: rtl/uftx_bit_timer.sv
module uftx_bit_timer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  logic tick,
    output logic bit_done
);
    localparam int CW = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign bit_done = run && tick && (cnt_q == LAST);
endmodule

// File: rtl/uftx_shifter.sv
module uftx_shifter
    import uftx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] data_in,
    input  fmt_t              fmt_in,
    input  logic              shift,
    output logic              lsb,
    output logic              par_bit
);
    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] sh_q;
    logic              par_q;
    logic [3:0]        nbits;

    assign nbits = data_count(fmt_in.len_m5);

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign keep[i] = (32'(i) < 32'(nbits));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            par_q <= 1'b0;
        end else if (load) begin
            sh_q  <= data_in & keep;
            par_q <= parity_out(fmt_in.par_mode, ^(data_in & keep));
        end else if (shift) begin
            sh_q  <= sh_q >> 1;
        end
    end

    assign lsb     = sh_q[0];
    assign par_bit = par_q;
endmodule

// File: rtl/uftx_sequencer.sv
module uftx_sequencer
    import uftx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   accept,
    input  fmt_t   fmt_in,
    input  logic   bit_done,
    output phase_e phase,
    output logic   shift
);
    localparam int IW = $clog2(DATA_W + 1);

    phase_e        phase_q;
    fmt_t          fmt_q;
    logic [IW-1:0] idx_q;
    logic          stop2_q;
    logic [3:0]    last_idx;

    assign last_idx = data_count(fmt_q.len_m5) - 4'd1;
    assign shift    = bit_done && (phase_q == PH_DATA);
    assign phase    = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            fmt_q   <= fmt_decode(CTRL_RESET);
            idx_q   <= '0;
            stop2_q <= 1'b0;
        end else if (accept) begin
            phase_q <= PH_START;
            fmt_q   <= fmt_in;
            idx_q   <= '0;
            stop2_q <= 1'b0;
        end else if (bit_done) begin
            unique case (phase_q)
                PH_START: phase_q <= PH_DATA;
                PH_DATA: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IW'(last_idx))
                        phase_q <= fmt_q.par_en ? PH_PARITY : PH_STOP;
                end
                PH_PARITY: phase_q <= PH_STOP;
                PH_STOP: begin
                    if (fmt_q.two_stop && !stop2_q)
                        stop2_q <= 1'b1;
                    else
                        phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uftx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_valid,
    output logic              char_ready,
    output logic              txd,
    output logic              busy
);
    logic [CTRL_W-1:0] ctrl_q;
    phase_e            phase;
    logic              accept, bit_done, shift, lsb, par_bit, line_bit;
    fmt_t              fmt_now;

    assign fmt_now    = fmt_decode(ctrl_q);
    assign busy       = (phase != PH_IDLE);
    assign char_ready = !busy;
    assign accept     = char_valid && char_ready;

    uftx_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .we(ctrl_we), .wdata(ctrl_wdata), .q(ctrl_q)
    );

    uftx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk(clk), .rst(rst), .restart(accept), .run(busy),
        .tick(tick16), .bit_done(bit_done)
    );

    uftx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .load(accept), .data_in(char_data),
        .fmt_in(fmt_now), .shift(shift), .lsb(lsb), .par_bit(par_bit)
    );

    uftx_sequencer #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst(rst), .accept(accept), .fmt_in(fmt_now),
        .bit_done(bit_done), .phase(phase), .shift(shift)
    );

    always_comb begin
        unique case (phase)
            PH_START:  line_bit = 1'b0;
            PH_DATA:   line_bit = lsb;
            PH_PARITY: line_bit = par_bit;
            default:   line_bit = 1'b1;
        endcase
    end

    assign txd = ctrl_q[BRK_BIT] ? 1'b0 : line_bit;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk
    import uftx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick16,
    input logic              ctrl_we,
    input logic              char_valid,
    input logic              char_ready,
    input logic              busy,
    input logic              txd,
    input logic [CTRL_W-1:0] ctrl_q
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_q == CTRL_RESET) && !busy);

    assert_hold_between_ticks_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick16 && !ctrl_we) |=> $stable(txd));

    assert_start_low_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);

    assert_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ctrl_q[BRK_BIT]) |-> txd);

    assert_break_low_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[BRK_BIT] |-> !txd);

    assert_accept_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (char_valid && char_ready) |=> (busy && !char_ready));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk(clk), .rst(rst), .tick16(tick16), .ctrl_we(ctrl_we),
    .char_valid(char_valid), .char_ready(char_ready), .busy(busy),
    .txd(txd), .ctrl_q(ctrl_q)
);

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [6:0] ctrl_wdata = '0;
    logic [7:0] char_data = '0;
    logic       char_valid = 1'b0;
    logic       char_ready, txd, busy;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int tdiv = 3;
    int tdc = 0;
    string cur_req = "R1";

    // reference model state
    bit    exp_bits[$];
    string exp_tags[$];
    int    ticks_left = 16;
    logic [6:0] m_ctrl = 7'h03;

    uart_frame_tx u_dut (
        .clk(clk), .rst(rst), .tick16(tick16), .ctrl_we(ctrl_we),
        .ctrl_wdata(ctrl_wdata), .char_data(char_data), .char_valid(char_valid),
        .char_ready(char_ready), .txd(txd), .busy(busy)
    );

    always #2.5 clk = ~clk;

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // tick generator, watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
        tick16 = (tdc == 0);
        tdc = (tdc + 1 >= tdiv) ? 0 : tdc + 1;
    end

    function automatic void push_frame(input logic [7:0] d, input logic [6:0] c);
        int n = int'(c[1:0]) + 5;
        int ones = 0;
        exp_bits.push_back(1'b0); exp_tags.push_back("R6 start");
        for (int i = 0; i < n; i++) begin
            exp_bits.push_back(d[i]); exp_tags.push_back("R2 data");
            if (d[i]) ones++;
        end
        if (c[3]) begin
            bit p;
            case (c[5:4])
                2'd0: p = (ones % 2 == 0);
                2'd1: p = (ones % 2 == 1);
                2'd2: p = 1'b1;
                default: p = 1'b0;
            endcase
            exp_bits.push_back(p); exp_tags.push_back("R4 parity");
        end
        exp_bits.push_back(1'b1); exp_tags.push_back("R3 stop");
        if (c[2]) begin
            exp_bits.push_back(1'b1); exp_tags.push_back("R3 stop2");
        end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_bits.delete(); exp_tags.delete();
            ticks_left = 16; m_ctrl = 7'h03;
        end else begin
            bit ready_pre;
            ready_pre = (exp_bits.size() == 0);
            if (tick16 && !ready_pre) begin
                ticks_left--;
                if (ticks_left == 0) begin
                    void'(exp_bits.pop_front());
                    void'(exp_tags.pop_front());
                    ticks_left = 16;
                end
            end
            if (char_valid && ready_pre) begin
                push_frame(char_data, m_ctrl);
                ticks_left = 16;
            end
            if (ctrl_we) m_ctrl = ctrl_wdata;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            bit e_busy, e_txd;
            string tag;
            e_busy = (exp_bits.size() != 0);
            e_txd  = m_ctrl[6] ? 1'b0 : (e_busy ? exp_bits[0] : 1'b1);
            tag    = m_ctrl[6] ? "R7 break" : (e_busy ? exp_tags[0] : "R6 idle");
            total++;
            if (txd !== e_txd || busy !== e_busy || char_ready !== !e_busy) begin
                bad++;
                $display("FAIL %s/%s: txd=%b busy=%b ready=%b expected txd=%b busy=%b ready=%b",
                         cur_req, tag, txd, busy, char_ready, e_txd, e_busy, !e_busy);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [6:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        @(negedge clk); char_valid = 1'b1; char_data = d;
        while (!char_ready) @(negedge clk);
        @(negedge clk); char_valid = 1'b0;
    endtask

    task automatic send_hold(input logic [7:0] d1, input logic [7:0] d2);
        @(negedge clk); char_valid = 1'b1; char_data = d1;
        while (!char_ready) @(negedge clk);
        @(negedge clk); char_data = d2;
        while (!char_ready) @(negedge clk);
        @(negedge clk); char_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 txd", int'(txd), 1);
        chk("R1 busy", int'(busy), 0);
        chk("R1 ready", int'(char_ready), 1);
        cur_req = "R1";
        send(8'hA5); wait_idle();

        // R2: widths 5..7
        cur_req = "R2";
        write_ctrl(7'h00); send(8'h15); wait_idle();
        write_ctrl(7'h01); send(8'h2B); wait_idle();
        write_ctrl(7'h02); send(8'h4E); wait_idle();

        // R3: two stop bits
        cur_req = "R3";
        write_ctrl(7'h07); send(8'hC3); wait_idle();

        // R4: all parity modes, odd and even data weight
        cur_req = "R4";
        for (int m = 0; m < 4; m++) begin
            write_ctrl(7'(8'h0B | (m << 4))); send(8'h07); wait_idle();
            send(8'h0F); wait_idle();
        end

        // R10: upper bits ignored in 5-bit mode with even parity
        cur_req = "R10";
        write_ctrl(7'h18); send(8'hE3); wait_idle();
        send(8'h03); wait_idle();

        // R5: frame length in cycles with a tick every cycle (7 data, parity, 2 stop)
        cur_req = "R5";
        tdiv = 1;
        write_ctrl(7'h1E);
        begin
            int n;
            send(8'h55);
            n = 1;
            forever begin
                @(negedge clk);
                if (busy) n++; else break;
            end
            chk("R5 frame cycles", n, 16 * 11);
        end
        tdiv = 3;

        // R9: format change mid-frame
        cur_req = "R9";
        write_ctrl(7'h03);
        send(8'h3C);
        repeat (40) @(negedge clk);
        write_ctrl(7'h0C);
        wait_idle();
        send(8'h1F); wait_idle();

        // R7: break idle and during a frame
        cur_req = "R7";
        write_ctrl(7'h43);
        repeat (20) @(negedge clk);
        chk("R7 idle break", int'(txd), 0);
        write_ctrl(7'h03);
        send(8'h81);
        repeat (50) @(negedge clk);
        write_ctrl(7'h43);
        repeat (30) @(negedge clk);
        chk("R7 frame break", int'(txd), 0);
        write_ctrl(7'h03);
        wait_idle();

        // R8: valid held through a frame, back-to-back acceptance
        cur_req = "R8";
        send_hold(8'h96, 8'h69);
        chk("R8 busy after second accept", int'(busy), 1);
        wait_idle();
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule